// File: doc/BRIEF.md
# Keyed-Lock Register Write Guard

This block sits between a simple memory-mapped register bus and a small bank of configuration registers. It decides, for every write, whether the write may land. Some registers each have a dedicated single-key lock. Writing the right key opens that lock for a short, fixed window. The remaining registers sit behind an optional global kick pair, which stays open only while both kick registers hold their keys. Reads are never blocked.

When the kick pair is left out at build time, the registers without a dedicated lock take every write. A write that is refused changes nothing. One cycle later it produces a single-cycle error pulse, so the failure can be seen from outside the block.

Top module: `keylock_guard`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads 0, every lock and kick register reads 0 (closed), and `wr_err` is 0.
- R2: Configuration registers sit at word addresses 0..5. Registers 0..3 are each guarded by a single-key lock at address 8+i, whose key is `LOCK_KEY_BASE + i`. Writing that key opens the lock. Reading a lock address returns 1 while the lock is open and 0 while it is closed, never the key.
- R3: Writing any nonzero value other than the key to a lock closes it (or leaves it closed), and the guarded register keeps its value.
- R4: After an accepted key write in cycle t, a write to the guarded register is accepted in cycles t+1 through t+`WINDOW` (default 8). A write in cycle t+`WINDOW`+1 or later is dropped.
- R5: Writing 0 to an open lock closes it at once, and a write to the guarded register in the next cycle is dropped.
- R6: With the kick pair built in, registers 4 and 5 accept writes only while kick register 0 (address 12) holds `KICK_KEY0` and kick register 1 (address 13) holds `KICK_KEY1`. Each kick address reads 1 when it holds its key. Writing 0 or a wrong value to either kick register closes access.
- R7: An open kick pair does not open registers 0..3. Those registers obey only their own lock.
- R8: With the kick pair left out (`KICK_EN`=0), registers 4 and 5 accept every write, and the kick addresses read 0.
- R9: A write to a guarded configuration register that is refused raises `wr_err` for exactly the following cycle. Accepted writes, lock writes and writes to unmapped addresses raise no error.
- R10: `bus_rdata` always shows the addressed register's current value, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | AW (4) | Word address for both reads and writes |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for `bus_addr` |
| wr_err | output | 1 | One-cycle pulse after a refused guarded write |
| cfg_q | output | NUM_CFG*DW (192) | All configuration registers, register j at bits j*DW +: DW |

## Verification
Some rules hold on every cycle, and the embedded assertions check those. A configuration register never changes unless the cycle before carried a write to it while its guard was open. A lock never opens without a key write on the previous cycle. A zero write always leaves a lock or kick pair closed. A single-key lock never stays open longer than the window. An error pulse is always preceded by a write into the configuration range.

Other behaviour needs the bench's scenarios to show it. These include the exact last cycle of the window, the rule that a kick pair never opens a locked register, the wrong-key cases, and the unconditional writes of the variant built without kicks. The bench checks them against a behavioural model on both the default build and the build without kicks.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  // key of single-key lock number idx
  function automatic logic [63:0] lock_key(input logic [63:0] base, input int idx);
    return base + 64'(idx);
  endfunction

  // bits needed to hold a countdown from w down to 0
  function automatic int win_bits(input int w);
    return $clog2(w + 1);
  endfunction

  // next countdown value of a single-key lock
  function automatic int unsigned next_count(input logic wr, input logic hit,
                                             input int unsigned cnt, input int unsigned win);
    if (wr) return hit ? win : 0;
    return (cnt != 0) ? cnt - 1 : 0;
  endfunction
endpackage

// File: rtl/keylock_single.sv
module keylock_single #(
  parameter int DW = 32,
  parameter int WINDOW = 8,
  parameter logic [DW-1:0] KEY = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_wr,
  input  logic [DW-1:0] wdata,
  output logic          open
);
  import keylock_pkg::*;
  localparam int CW = win_bits(WINDOW);

  logic [CW-1:0] cnt;
  logic          key_hit;
  logic          zero_hit;

  assign key_hit  = lk_wr && (wdata == KEY);
  assign zero_hit = lk_wr && (wdata == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CW'(next_count(lk_wr, key_hit, 32'(cnt), 32'(WINDOW)));
  end

  assign open = (cnt != '0);

  // open-cycle run length since the last key write, for the window check
  logic [CW:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n || key_hit || !open) run <= '0;
    else                            run <= run + 1'b1;
  end

  // R2
  lock_open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(key_hit));

  // R5
  zero_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> !open);

  // R4
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> (run < (CW+1)'(WINDOW)));
endmodule

// File: rtl/keylock_kick.sv
module keylock_kick #(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY0 = '1,
  parameter logic [DW-1:0] KEY1 = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    kick_wr,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    kick_ok,
  output logic          kick_open
);
  for (genvar k = 0; k < 2; k++) begin : g_kick
    localparam logic [DW-1:0] KEY = (k == 0) ? KEY0 : KEY1;
    always_ff @(posedge clk) begin
      if (!rst_n)          kick_ok[k] <= 1'b0;
      else if (kick_wr[k]) kick_ok[k] <= (wdata == KEY);
    end
  end

  assign kick_open = &kick_ok;

  // R6
  kick_open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kick_open) |-> $past(|kick_wr));

  // R6
  kick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|kick_wr) && wdata == '0) |=> !kick_open);
endmodule

// File: rtl/keylock_guard.sv
module keylock_guard #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int NUM_LOCKED = 4,
  parameter int NUM_FREE = 2,
  parameter int WINDOW = 8,
  parameter bit KICK_EN = 1'b1,
  parameter logic [DW-1:0] LOCK_KEY_BASE = 32'h5EC0_0000,
  parameter logic [DW-1:0] KICK_KEY0 = 32'hC0DE_1357,
  parameter logic [DW-1:0] KICK_KEY1 = 32'h2468_ACE0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [AW-1:0]                 bus_addr,
  input  logic [DW-1:0]                 bus_wdata,
  output logic [DW-1:0]                 bus_rdata,
  output logic                          wr_err,
  output logic [(NUM_LOCKED+NUM_FREE)*DW-1:0] cfg_q
);
  import keylock_pkg::*;
  localparam int NUM_CFG   = NUM_LOCKED + NUM_FREE;
  localparam int LOCK_BASE = 2 ** $clog2(NUM_CFG);
  localparam int KICK_BASE = LOCK_BASE + 2 ** $clog2(NUM_LOCKED);

  logic [NUM_LOCKED-1:0] lock_wr, lock_open;
  logic [1:0]            kick_wr, kick_ok;
  logic                  kick_open;
  logic [NUM_CFG-1:0]    cfg_wr, cfg_ok;
  logic [DW-1:0]         cfg_r [NUM_CFG];
  logic                  deny;

  // address decode
  always_comb begin
    for (int i = 0; i < NUM_CFG; i++)    cfg_wr[i]  = bus_wr && (bus_addr == AW'(i));
    for (int i = 0; i < NUM_LOCKED; i++) lock_wr[i] = bus_wr && (bus_addr == AW'(LOCK_BASE + i));
    for (int k = 0; k < 2; k++)          kick_wr[k] = bus_wr && (bus_addr == AW'(KICK_BASE + k));
  end

  for (genvar i = 0; i < NUM_LOCKED; i++) begin : g_lock
    keylock_single #(
      .DW(DW), .WINDOW(WINDOW),
      .KEY(DW'(lock_key(64'(LOCK_KEY_BASE), i)))
    ) u_lock (
      .clk(clk), .rst_n(rst_n), .lk_wr(lock_wr[i]),
      .wdata(bus_wdata), .open(lock_open[i])
    );
  end

  if (KICK_EN) begin : g_kick
    keylock_kick #(.DW(DW), .KEY0(KICK_KEY0), .KEY1(KICK_KEY1)) u_kick (
      .clk(clk), .rst_n(rst_n), .kick_wr(kick_wr), .wdata(bus_wdata),
      .kick_ok(kick_ok), .kick_open(kick_open)
    );
  end else begin : g_nokick
    assign kick_ok   = 2'b00;
    assign kick_open = 1'b1;
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    if (g < NUM_LOCKED) begin : g_own
      assign cfg_ok[g] = lock_open[g];
    end else begin : g_shared
      assign cfg_ok[g] = kick_open;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                       cfg_r[g] <= '0;
      else if (cfg_wr[g] && cfg_ok[g])  cfg_r[g] <= bus_wdata;
    end

    assign cfg_q[g*DW +: DW] = cfg_r[g];

    // R4 R6 R7
    cfg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_r[g] != $past(cfg_r[g])) |-> $past(cfg_wr[g] && cfg_ok[g]));
  end

  assign deny = |(cfg_wr & ~cfg_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= deny;
  end

  // read mux, never gated
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (bus_addr == AW'(i)) bus_rdata = cfg_r[i];
    for (int i = 0; i < NUM_LOCKED; i++)
      if (bus_addr == AW'(LOCK_BASE + i)) bus_rdata = DW'(lock_open[i]);
    for (int k = 0; k < 2; k++)
      if (bus_addr == AW'(KICK_BASE + k)) bus_rdata = DW'(kick_ok[k]);
  end

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(bus_wr && (bus_addr < AW'(NUM_CFG))));
endmodule

// File: tb/keylock_guard_tb.sv
module keylock_guard_tb;
  localparam int W = 8;
  localparam logic [31:0] LKEY = 32'h5EC0_0000;
  localparam logic [31:0] K0 = 32'hC0DE_1357;
  localparam logic [31:0] K1 = 32'h2468_ACE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic err0, err1;
  logic [191:0] cq0, cq1;

  always #4 clk = ~clk;

  keylock_guard u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .wr_err(err0), .cfg_q(cq0));
  keylock_guard #(.KICK_EN(1'b0)) u_dut_nokick (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1), .wr_err(err1), .cfg_q(cq1));

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // behavioural model: index 0 = kick pair built in, 1 = without
  logic [31:0] m_cfg [2][6];
  int          m_cnt [2][4];
  bit          m_kok [2][2];
  bit          m_err [2];

  function automatic logic [31:0] m_read(int d, logic [3:0] a);
    if (a < 6) return m_cfg[d][a];
    if (a >= 8 && a < 12) return (m_cnt[d][a-8] > 0) ? 32'd1 : 32'd0;
    if (a == 12 || a == 13) return (d == 0 && m_kok[d][a-12]) ? 32'd1 : 32'd0;
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        for (int j = 0; j < 6; j++) m_cfg[d][j] = '0;
        for (int j = 0; j < 4; j++) m_cnt[d][j] = 0;
        m_kok[d][0] = 0; m_kok[d][1] = 0; m_err[d] = 0;
      end else begin
        bit allow;
        m_err[d] = 0;
        if (bus_wr && bus_addr < 6) begin
          if (bus_addr < 4) allow = m_cnt[d][bus_addr] > 0;
          else allow = (d == 1) || (m_kok[d][0] && m_kok[d][1]);
          if (allow) m_cfg[d][bus_addr] = bus_wdata;
          else m_err[d] = 1;
        end
        for (int j = 0; j < 4; j++)
          if (bus_wr && bus_addr == 4'(8 + j))
            m_cnt[d][j] = (bus_wdata == LKEY + 32'(j)) ? W : 0;
          else if (m_cnt[d][j] > 0)
            m_cnt[d][j] = m_cnt[d][j] - 1;
        if (d == 0 && bus_wr && bus_addr == 12) m_kok[d][0] = (bus_wdata == K0);
        if (d == 0 && bus_wr && bus_addr == 13) m_kok[d][1] = (bus_wdata == K1);
      end
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int j = 0; j < 6; j++) begin
        cmp((j < 4) ? "R4 cfg dut0" : "R6 cfg dut0", cq0[j*32 +: 32], m_cfg[0][j]);
        cmp((j < 4) ? "R4 cfg dut1" : "R8 cfg dut1", cq1[j*32 +: 32], m_cfg[1][j]);
      end
      cmp("R9 wr_err dut0", 32'(err0), 32'(m_err[0]));
      cmp("R9 wr_err dut1", 32'(err1), 32'(m_err[1]));
      cmp("R10 rdata dut0", rd0, m_read(0, bus_addr));
      cmp("R10 rdata dut1", rd1, m_read(1, bus_addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] v);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; bus_wr = 1'b0; end
  endtask

  // read in the next cycle and check at mid-cycle against a hand value
  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp0, logic [31:0] exp1);
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    cmp(tag, rd0, exp0);
    cmp(tag, rd1, exp1);
  endtask

  initial begin
    idle(3);
    @(posedge clk); #1; rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 14; a++) rd("R1 reset read", 4'(a), 32'd0, 32'd0);
    @(negedge clk); cmp("R1 wr_err", 32'(err0), 32'd0);

    // R2 R4: open lock 0, write at once
    wr(8, LKEY);
    wr(0, 32'hAAAA_0001);
    rd("R2 lock0 reads open", 8, 32'd1, 32'd1);
    rd("R4 cfg0 accepted", 0, 32'hAAAA_0001, 32'hAAAA_0001);

    // R3: wrong key, write dropped with error
    wr(9, LKEY + 32'd7);
    wr(1, 32'hBBBB_0002);
    @(posedge clk); #1; bus_wr = 1'b0;
    @(negedge clk); cmp("R9 err after deny", 32'(err0), 32'd1);
    rd("R3 cfg1 unchanged", 1, 32'd0, 32'd0);
    rd("R3 lock1 closed", 9, 32'd0, 32'd0);

    // R4: last cycle of window accepted, one later dropped
    wr(11, LKEY + 32'd3); idle(W - 1); wr(3, 32'hCCCC_0003);
    rd("R4 cfg3 edge accepted", 3, 32'hCCCC_0003, 32'hCCCC_0003);
    wr(10, LKEY + 32'd2); idle(W); wr(2, 32'hDDDD_0004);
    rd("R4 cfg2 late dropped", 2, 32'd0, 32'd0);

    // R5: zero closes immediately
    wr(8, LKEY); wr(8, 32'd0); wr(0, 32'hEEEE_0005);
    rd("R5 cfg0 kept", 0, 32'hAAAA_0001, 32'hAAAA_0001);

    // R6 R8: kick pair
    wr(4, 32'h1111_0006);
    rd("R6 cfg4 closed kick", 4, 32'd0, 32'h1111_0006);
    wr(12, K0); wr(13, K1);
    rd("R6 kick1 reads set", 13, 32'd1, 32'd0);
    wr(4, 32'h2222_0007);
    rd("R6 cfg4 open kick", 4, 32'h2222_0007, 32'h2222_0007);
    // R7: kick does not open locked registers
    wr(1, 32'h3333_0008);
    rd("R7 cfg1 still locked", 1, 32'd0, 32'd0);
    wr(12, 32'd0); wr(5, 32'h4444_0009);
    rd("R6 cfg5 after kick zero", 5, 32'd0, 32'h4444_0009);
    wr(12, K0); wr(13, K1 ^ 32'd1); wr(5, 32'h5555_000A);
    rd("R6 cfg5 wrong kick", 5, 32'd0, 32'h5555_000A);

    // R9: unmapped write gives no error
    wr(15, 32'h1234_5678);
    @(posedge clk); #1; bus_wr = 1'b0;
    @(negedge clk); cmp("R9 no err unmapped", 32'(err0), 32'd0);

    // R10: reads while locked
    rd("R10 cfg3 read locked", 3, 32'hCCCC_0003, 32'hCCCC_0003);
    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog (R1) actual=%0d cycles expected=end of scenario", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule